// File: doc/BRIEF.md
# Simultaneous Conversion-Start Timer

This block paces a bank of analog-to-digital converters. A host writes a 32-bit period count, in converter-clock cycles, and a per-channel enable mask. While at least one channel is enabled, a free-running period counter expires once per period. Each expiry produces a single-cycle start pulse on every enabled channel at once. Disabled channels never see a pulse.

The converters cannot finish a conversion faster than a fixed minimum time. The period is therefore clamped to a minimum count, which is derived from that time and the clock period (250 cycles at 8 ns for 2 µs). A count of zero selects this fastest rate.

A shared busy input from the conversion handshake holds back a start pulse while the converters are still working. At most one held pulse is kept. The period grid is not shifted by the hold.

Top module: `sample_rate_timer`

## Requirements
- R1: With a stored count C at or above the minimum count M (default 250), enabled channels are started every C clock cycles.
- R2: A stored count of zero gives a period of M cycles.
- R3: A nonzero stored count below M gives a period of M cycles.
- R4: The count register (wr_sel = 0) is written only when all four byte enables wr_be are 1. A write with any other byte-enable pattern changes neither the count nor the timing phase.
- R5: conv_start bit i is 1 only if channel i is enabled in the mask (wr_sel = 1, data bits [NUM_CH-1:0], bit i = channel i, 1 = converting).
- R6: Every enabled channel is started in the same cycle: a nonzero conv_start equals the enable mask.
- R7: While the mask is all zero, conv_start stays zero.
- R8: A full count write, or a mask write that takes the mask from all zero to nonzero, restarts the period. The first start then appears P cycles after the write's clock edge, where P is the effective period. A mask change between two nonzero values does not restart the period.
- R9: If conv_busy is 1 on the edge where the period expires, the start pulse is held back. It is issued one cycle after the first edge on which conv_busy is 0. Later starts stay on the original grid.
- R10: A restart that falls on the same edge as a period expiry cancels that start and begins a new period.
- R11: After reset, conv_start is zero, the count is zero and the mask is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = period count, 1 = enable mask |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data |
| conv_busy | input | 1 | Converters still busy with the previous conversion |
| conv_start | output | 16 | One-cycle conversion start, one bit per channel |

## Verification
Several functions can fall on the same edge: a restart from a register write and a period expiry, and also a busy hold and an expiry. The bench provokes the first case by placing a full count write exactly on the expiry edge. It then expects no pulse on that edge and the next pulse one full new period later. For the busy case, conv_busy is held high across an expiry and released 20 cycles later. The bench expects the held pulse one cycle after the release and the next pulse on the undisturbed grid. A behavioural model compares conv_start on every cycle throughout.

// File: rtl/srt_pkg.sv
package srt_pkg;

    localparam int CNT_W = 32;
    localparam int BE_W  = CNT_W / 8;

    typedef enum logic {
        TGT_PERIOD = 1'b0,
        TGT_MASK   = 1'b1
    } wr_target_e;

    typedef struct packed {
        logic             valid;
        wr_target_e       target;
        logic [BE_W-1:0]  be;
        logic [CNT_W-1:0] data;
    } wr_req_t;

    // Clamp a programmed count to the converter's minimum period.
    function automatic logic [CNT_W-1:0] clamp_period(
        input logic [CNT_W-1:0] raw,
        input logic [CNT_W-1:0] floor_cnt
    );
        return (raw < floor_cnt) ? floor_cnt : raw;
    endfunction

endpackage

// File: rtl/srt_regs.sv
module srt_regs
    import srt_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           req,
    output logic [CNT_W-1:0]  count_q,
    output logic [NUM_CH-1:0] mask_q,
    output logic              restart
);
    localparam logic [BE_W-1:0] FULL_BE = '1;

    logic period_wr;
    logic mask_wr;

    assign period_wr = req.valid && (req.target == TGT_PERIOD) && (req.be == FULL_BE);
    assign mask_wr   = req.valid && (req.target == TGT_MASK);

    assign restart = period_wr ||
                     (mask_wr && (mask_q == '0) && (req.data[NUM_CH-1:0] != '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            mask_q  <= '0;
        end else begin
            if (period_wr) count_q <= req.data;
            if (mask_wr)   mask_q  <= req.data[NUM_CH-1:0];
        end
    end

endmodule

// File: rtl/srt_period.sv
module srt_period
    import srt_pkg::*;
#(
    parameter int MIN_CNT = 250
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count_q,
    input  logic             active,
    input  logic             restart,
    output logic             expire
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_CNT);

    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] phase_q;
    logic             at_end;

    assign period = clamp_period(count_q, FLOOR);
    assign at_end = (phase_q == period - 1'b1);
    assign expire = active && at_end && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart || !active || at_end) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/srt_issue.sv
module srt_issue #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              expire,
    input  logic              restart,
    input  logic              busy,
    input  logic [NUM_CH-1:0] mask_q,
    output logic [NUM_CH-1:0] start_q
);
    logic active;
    logic held_q;
    logic fire;

    assign active = (mask_q != '0);
    assign fire   = (expire || held_q) && !busy && active && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart || !active) begin
            held_q <= 1'b0;
        end else begin
            held_q <= (expire || held_q) && busy;
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                start_q[ch] <= 1'b0;
            end else begin
                start_q[ch] <= fire && mask_q[ch];
            end
        end
    end

endmodule

// File: rtl/sample_rate_timer.sv
module sample_rate_timer
    import srt_pkg::*;
#(
    parameter int NUM_CH        = 16,
    parameter int CLK_PS        = 8000,
    parameter int MIN_PERIOD_PS = 2000000,
    localparam int MIN_CNT      = (MIN_PERIOD_PS + CLK_PS - 1) / CLK_PS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [3:0]        wr_be,
    input  logic [31:0]       wr_data,
    input  logic              conv_busy,
    output logic [NUM_CH-1:0] conv_start
);
    wr_req_t           req;
    logic [CNT_W-1:0]  cnt_reg;
    logic [NUM_CH-1:0] en_mask;
    logic              restart;
    logic              expire;

    assign req.valid  = wr_en;
    assign req.target = wr_target_e'(wr_sel);
    assign req.be     = wr_be;
    assign req.data   = wr_data;

    srt_regs #(.NUM_CH(NUM_CH)) i_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .count_q (cnt_reg),
        .mask_q  (en_mask),
        .restart (restart)
    );

    srt_period #(.MIN_CNT(MIN_CNT)) i_period (
        .clk     (clk),
        .rst     (rst),
        .count_q (cnt_reg),
        .active  (en_mask != '0),
        .restart (restart),
        .expire  (expire)
    );

    srt_issue #(.NUM_CH(NUM_CH)) i_issue (
        .clk     (clk),
        .rst     (rst),
        .expire  (expire),
        .restart (restart),
        .busy    (conv_busy),
        .mask_q  (en_mask),
        .start_q (conv_start)
    );

endmodule

// File: rtl/srt_checker.sv
module srt_checker #(
    parameter int NUM_CH = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [3:0]        wr_be,
    input logic              conv_busy,
    input logic [NUM_CH-1:0] conv_start,
    input logic [31:0]       cnt_reg,
    input logic [NUM_CH-1:0] en_mask,
    input logic              restart
);
    // R4
    partial_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && wr_be != 4'hF) |=> $stable(cnt_reg));

    // R6
    same_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_start != '0) |-> (conv_start == $past(en_mask)));

    // R7
    idle_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en_mask) == '0) |-> (conv_start == '0));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_start != '0) |-> !$past(conv_busy));

    // R10
    restart_wins_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (conv_start == '0));
endmodule

bind sample_rate_timer srt_checker #(.NUM_CH(NUM_CH)) i_srt_checker (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_be      (wr_be),
    .conv_busy  (conv_busy),
    .conv_start (conv_start),
    .cnt_reg    (cnt_reg),
    .en_mask    (en_mask),
    .restart    (restart)
);

// File: tb/test_sample_rate_timer.sv
`timescale 1ns/1ps
module test_sample_rate_timer;
    localparam int NCH = 16;
    localparam longint MINC = 250;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic           wr_sel = 1'b0;
    logic [3:0]     wr_be = 4'h0;
    logic [31:0]    wr_data = '0;
    logic           conv_busy = 1'b0;
    logic [NCH-1:0] conv_start;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int stamps[$];
    logic [NCH-1:0] vals[$];

    sample_rate_timer i_sample_rate_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
        .wr_data(wr_data), .conv_busy(conv_busy), .conv_start(conv_start)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural reference: period length and phase tracked with integers.
    longint         m_phase = 0, m_count = 0, m_per;
    logic [NCH-1:0] m_mask = '0, m_start = '0;
    bit             m_held = 0, m_rs, m_exp, m_fire;
    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_count = 0; m_mask = '0; m_start = '0; m_held = 0;
        end else begin
            m_per = (m_count < MINC) ? MINC : m_count;
            m_rs  = (wr_en && !wr_sel && wr_be == 4'hF) ||
                    (wr_en && wr_sel && m_mask == 0 && wr_data[NCH-1:0] != 0);
            m_exp = (m_mask != 0) && (m_phase == m_per - 1) && !m_rs;
            m_fire = (m_exp || m_held) && !conv_busy && (m_mask != 0) && !m_rs;
            m_start = m_fire ? m_mask : '0;
            m_held = (m_rs || m_mask == 0) ? 1'b0 : ((m_exp || m_held) && conv_busy);
            m_phase = (m_rs || m_mask == 0 || m_phase == m_per - 1) ? 0 : m_phase + 1;
            if (wr_en && !wr_sel && wr_be == 4'hF) m_count = wr_data;
            if (wr_en && wr_sel) m_mask = wr_data[NCH-1:0];
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check(conv_start == m_start, "R6 per-cycle model", conv_start, m_start);
            if (conv_start != 0) begin
                stamps.push_back(cyc);
                vals.push_back(conv_start);
            end
        end
    end

    task automatic do_write(input logic sel, input logic [3:0] be, input logic [31:0] d,
                            output int w);
        wr_en = 1'b1; wr_sel = sel; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 4'h0;
        w = cyc;
    endtask

    task automatic go_to(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic wait_n(input int n);
        int lim = cyc + 2000;
        while (stamps.size() < n && cyc < lim) @(negedge clk);
    endtask

    task automatic flush();
        @(negedge clk);
        stamps.delete();
        vals.delete();
    endtask

    initial begin
        #1500000;
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w, w2, s0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(conv_start == 0, "R11 reset start", conv_start, 0);
        repeat (20) @(negedge clk);
        check(stamps.size() == 0, "R11 no start after reset", stamps.size(), 0);

        // R2, R8: count is zero after reset; enabling one channel restarts
        do_write(1'b1, 4'hF, 32'h0001, w); flush();
        wait_n(2);
        check(stamps[0] == w + 250, "R8 first start after enable", stamps[0], w + 250);
        check(stamps[1] - stamps[0] == 250, "R2 zero count period", stamps[1] - stamps[0], 250);
        check(vals[0] == 16'h0001, "R5 only enabled lane", vals[0], 16'h0001);

        // R3: count below minimum
        do_write(1'b0, 4'hF, 32'd100, w); flush();
        wait_n(2);
        check(stamps[0] == w + 250, "R3 first start", stamps[0], w + 250);
        check(stamps[1] - stamps[0] == 250, "R3 clamped period", stamps[1] - stamps[0], 250);

        // R1: count above minimum
        do_write(1'b0, 4'hF, 32'd300, w); flush();
        wait_n(2);
        check(stamps[0] == w + 300, "R1 first start", stamps[0], w + 300);
        check(stamps[1] - stamps[0] == 300, "R1 period", stamps[1] - stamps[0], 300);

        // R4: partial write ignored, phase kept
        s0 = stamps[1];
        go_to(s0 + 100);
        do_write(1'b0, 4'h3, 32'd1000, w); flush();
        wait_n(1);
        check(stamps[0] == s0 + 300, "R4 partial write ignored", stamps[0], s0 + 300);

        // R5, R6, R8: nonzero-to-nonzero mask, no restart
        s0 = stamps[0];
        go_to(s0 + 50);
        do_write(1'b1, 4'hF, 32'hA5A5, w); flush();
        wait_n(1);
        check(stamps[0] == s0 + 300, "R8 no restart on mask change", stamps[0], s0 + 300);
        check(vals[0] == 16'hA5A5, "R6 all enabled lanes together", vals[0], 16'hA5A5);

        // R7: empty mask stops everything
        do_write(1'b1, 4'hF, 32'h0000, w); flush();
        repeat (700) @(negedge clk);
        check(stamps.size() == 0, "R7 no start with empty mask", stamps.size(), 0);

        // R9: busy across an expiry
        do_write(1'b1, 4'hF, 32'hFFFF, w); flush();
        go_to(w + 250);
        conv_busy = 1'b1;
        go_to(w + 320);
        conv_busy = 1'b0;
        wait_n(2);
        check(stamps[0] == w + 321, "R9 held start after busy", stamps[0], w + 321);
        check(stamps[1] == w + 600, "R9 grid kept", stamps[1], w + 600);
        check(vals[0] == 16'hFFFF, "R6 full mask", vals[0], 16'hFFFF);

        // R10: full count write on the expiry edge
        flush();
        go_to(w + 899);
        do_write(1'b0, 4'hF, 32'd400, w2); flush();
        wait_n(1);
        check(w2 == w + 900, "R10 write placed on expiry", w2, w + 900);
        check(stamps[0] == w2 + 400, "R10 restart wins", stamps[0], w2 + 400);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule